// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block gathers interrupt sources into two CPU request lines through a byte-wide register port. Two local banks of eight sources each (level 0 and level 1) are sampled every clock into raw status registers. Each bank has its own mask register, and the bank drives its own CPU request line. A third group of eight shared ("mappable") sources has one status byte and two mask bytes. Mask A folds the selected shared sources into level 0 bit 7. Mask B folds them into level 1 bit 3. One shared source can therefore reach either CPU level, or both.

Two timer tick inputs are caught on their rising edge into sticky flags. Each flag drives its own output line until software clears it through a write-only clear register. Software reads status and masks with one cycle of read latency and combines them itself. Status bytes are never gated by a mask.

Top module: `irq_cascade_ctl`

## Requirements
- R1: After reset all four mask registers read 0x00, both CPU request lines and both timer lines are low, and no request rises while the masks stay zero, whatever the sources do.
- R2: The status bytes at offset 0x00 (level 0), 0x02 (level 1) and 0x04 (shared) return the source inputs sampled at the previous clock edge, whatever the masks hold. Level 0 bit 7 is source bit 7 ORed with the cascade A term. Level 1 bit 3 is source bit 3 ORed with the cascade B term.
- R3: Each CPU request line is a register loaded with the OR of (bank status AND bank mask). A mask written at edge e changes the request at edge e+1.
- R4: Cascade A is the OR of (shared sources AND mask A) and reaches level 0 bit 7. Cascade B is the OR of (shared sources AND mask B) and reaches level 1 bit 3. Neither term touches the other bank.
- R5: The mask registers are read/write at 0x01 (level 0), 0x03 (level 1), 0x08 (shared mask A) and 0x0C (shared mask B, four bytes above A).
- R6: Writes to any status offset are ignored. Level 0 bit 0 is a level-sensitive FIFO-full condition: it reads 1 for as long as its input is high, and a write cannot clear it.
- R7: A rising edge on tick input k sets sticky flag k. The flag drives output line k until it is cleared.
- R8: A write to 0x10 clears flag 0 when data bit 0 is 1 and flag 1 when data bit 1 is 1. A write of 0x03 clears both flags.
- R9: When a rising tick edge and a clear for the same flag fall in one cycle, the flag ends up set.
- R10: A read strobe at edge e puts the data on the read port after edge e. With no read strobe the read port is 0x00. Reads of the clear register and of every unmapped offset return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l0_src | input | 8 | Level 0 source lines (bit 0 is FIFO-full) |
| l1_src | input | 8 | Level 1 source lines |
| mp_src | input | 8 | Shared source lines |
| tick_in | input | 2 | Timer tick inputs, rising-edge latched |
| addr | input | ADDR_W | Byte offset of the register access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, one cycle after the strobe |
| cpu_irq0 | output | 1 | CPU request from level 0 |
| cpu_irq1 | output | 1 | CPU request from level 1 |
| tick_irq | output | 2 | Sticky timer interrupt lines |

## Verification
Two functions can fall in the same cycle: a fresh rising edge on a timer tick, and a clear-register write aimed at that flag. The bench raises tick 0 from low in the same cycle as a clear of both flags, after it has already set flag 1. Flag 0 must come out set and flag 1 must come out cleared. A similar collision is a mask write landing while the status is nonzero. The bench checks that the request holds its old value for exactly one edge and then follows the new mask.

// File: rtl/irq_cascade_ctl.sv
module irq_cascade_ctl #(
  parameter int ADDR_W    = 5,
  parameter int OFS_L0S   = 'h00,
  parameter int OFS_L0M   = 'h01,
  parameter int OFS_L1S   = 'h02,
  parameter int OFS_L1M   = 'h03,
  parameter int OFS_MPS   = 'h04,
  parameter int OFS_MPA   = 'h08,
  parameter int MP_STRIDE = 4,
  parameter int OFS_CLR   = 'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        l0_src,
  input  logic [7:0]        l1_src,
  input  logic [7:0]        mp_src,
  input  logic [1:0]        tick_in,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  output logic [7:0]        rd_data,
  output logic              cpu_irq0,
  output logic              cpu_irq1,
  output logic [1:0]        tick_irq
);

  localparam logic [ADDR_W-1:0] A_L0S = ADDR_W'(OFS_L0S);
  localparam logic [ADDR_W-1:0] A_L0M = ADDR_W'(OFS_L0M);
  localparam logic [ADDR_W-1:0] A_L1S = ADDR_W'(OFS_L1S);
  localparam logic [ADDR_W-1:0] A_L1M = ADDR_W'(OFS_L1M);
  localparam logic [ADDR_W-1:0] A_MPS = ADDR_W'(OFS_MPS);
  localparam logic [ADDR_W-1:0] A_MPA = ADDR_W'(OFS_MPA);
  localparam logic [ADDR_W-1:0] A_MPB = ADDR_W'(OFS_MPA + MP_STRIDE);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(OFS_CLR);

  logic [7:0] l0_stat, l1_stat, mp_stat;
  logic [7:0] l0_mask, l1_mask, mp_mask_a, mp_mask_b;
  logic [1:0] tick_prev;
  logic [7:0] rd_mux;
  logic       unmapped;

  wire casc_a = |(mp_src & mp_mask_a);
  wire casc_b = |(mp_src & mp_mask_b);

  wire [1:0] tick_rise = tick_in & ~tick_prev;
  wire [1:0] tick_clr  = (wr_en && addr == A_CLR) ? wr_data[1:0] : 2'b00;

  always_comb begin
    rd_mux   = 8'h00;
    unmapped = 1'b0;
    case (addr)
      A_L0S:   rd_mux = l0_stat;
      A_L0M:   rd_mux = l0_mask;
      A_L1S:   rd_mux = l1_stat;
      A_L1M:   rd_mux = l1_mask;
      A_MPS:   rd_mux = mp_stat;
      A_MPA:   rd_mux = mp_mask_a;
      A_MPB:   rd_mux = mp_mask_b;
      default: unmapped = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l0_stat   <= '0;
      l1_stat   <= '0;
      mp_stat   <= '0;
      l0_mask   <= '0;
      l1_mask   <= '0;
      mp_mask_a <= '0;
      mp_mask_b <= '0;
      tick_prev <= '0;
      tick_irq  <= '0;
      cpu_irq0  <= 1'b0;
      cpu_irq1  <= 1'b0;
      rd_data   <= '0;
    end else begin
      l0_stat   <= l0_src | {casc_a, 7'b0};
      l1_stat   <= l1_src | {4'b0, casc_b, 3'b0};
      mp_stat   <= mp_src;
      if (wr_en && addr == A_L0M) l0_mask   <= wr_data;
      if (wr_en && addr == A_L1M) l1_mask   <= wr_data;
      if (wr_en && addr == A_MPA) mp_mask_a <= wr_data;
      if (wr_en && addr == A_MPB) mp_mask_b <= wr_data;
      cpu_irq0  <= |(l0_stat & l0_mask);
      cpu_irq1  <= |(l1_stat & l1_mask);
      tick_prev <= tick_in;
      tick_irq  <= tick_rise | (tick_irq & ~tick_clr);
      rd_data   <= rd_en ? rd_mux : 8'h00;
    end
  end

  assert_quiet_masks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (l0_mask == 8'h00 && l1_mask == 8'h00) |=> (!cpu_irq0 && !cpu_irq1));

  assert_mask_zero_drops_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_L0M && wr_data == 8'h00) |-> ##2 !cpu_irq0);

  assert_fifo_full_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    l0_src[0] |=> l0_stat[0]);

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_in[0] && !tick_prev[0] && tick_clr[0]) |=> tick_irq[0]);

  assert_clear_works_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_clr[1] && !(tick_in[1] && !tick_prev[1])) |=> !tick_irq[1]);

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && unmapped) |=> rd_data == 8'h00);

  assert_cascade_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(mp_src & mp_mask_a)) |=> l0_stat[7]);

endmodule

// File: tb/sim_irq_cascade_ctl.sv
module sim_irq_cascade_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] l0_src = 8'h00, l1_src = 8'h00, mp_src = 8'h00;
  logic [1:0] tick_in = 2'b00;
  logic [4:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       cpu_irq0, cpu_irq1;
  logic [1:0] tick_irq;
  int n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  irq_cascade_ctl u0 (.clk(clk), .rst_n(rst_n), .l0_src(l0_src), .l1_src(l1_src),
    .mp_src(mp_src), .tick_in(tick_in), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .cpu_irq0(cpu_irq0), .cpu_irq1(cpu_irq1),
    .tick_irq(tick_irq));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    step();
    d = rd_data;
    rd_en = 1'b0;
  endtask

  function automatic logic [7:0] mval(input int i);
    if (i == 0) return 8'h00;
    if (i <= 8) return 8'h01 << (i - 1);
    if (i == 9) return 8'hFF;
    return 8'h5A;
  endfunction

  initial begin
    logic [7:0] d;
    logic [7:0] exp;
    repeat (10000000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] exp;
    l0_src = 8'hFF; l1_src = 8'hFF; mp_src = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(); step();
    // R1: reset state with all sources high
    chk(cpu_irq0 == 0 && cpu_irq1 == 0, "R1 req low after reset", {cpu_irq1, cpu_irq0}, 0);
    chk(tick_irq == 2'b00, "R1 timer lines low", tick_irq, 0);
    foreach (u0.A_L0M[i]) ; // no-op keeps loop syntax local
    rd(5'h01, d); chk(d == 8'h00, "R1 l0 mask reset", d, 0);
    rd(5'h03, d); chk(d == 8'h00, "R1 l1 mask reset", d, 0);
    rd(5'h08, d); chk(d == 8'h00, "R1 mask A reset", d, 0);
    rd(5'h0C, d); chk(d == 8'h00, "R1 mask B reset", d, 0);
    step();
    chk(rd_data == 8'h00, "R10 idle read port", rd_data, 0);

    // R2: raw status sweep, masks set to 0xFF so gating would show
    l0_src = 0; l1_src = 0; mp_src = 0;
    wr(5'h01, 8'hFF); wr(5'h03, 8'hFF);
    for (int s = 0; s < 256; s++) begin
      l0_src = 8'(s); l1_src = 8'(~s); mp_src = 8'(s ^ 8'h3C);
      step();
      rd(5'h00, d); chk(d == 8'(s), "R2 l0 status", d, s);
      rd(5'h02, d); chk(d == 8'(~s), "R2 l1 status", d, 8'(~s));
      rd(5'h04, d); chk(d == 8'(s ^ 8'h3C), "R2 shared status", d, s ^ 8'h3C);
    end

    // R3: request = OR(status & mask), several masks x all sources
    for (int bank = 0; bank < 2; bank++) begin
      for (int mi = 0; mi < 11; mi++) begin
        wr(bank == 0 ? 5'h01 : 5'h03, mval(mi));
        for (int s = 0; s < 256; s++) begin
          if (bank == 0) l0_src = 8'(s); else l1_src = 8'(s);
          step(); step();
          exp = 8'(s) & mval(mi);
          if (bank == 0) chk(cpu_irq0 == (exp != 0), "R3 level0 request", cpu_irq0, exp != 0);
          else           chk(cpu_irq1 == (exp != 0), "R3 level1 request", cpu_irq1, exp != 0);
        end
      end
    end

    // R3: mask write timing
    l0_src = 8'h10; wr(5'h01, 8'hFF); step();
    chk(cpu_irq0 == 1, "R3 req before mask clear", cpu_irq0, 1);
    wr(5'h01, 8'h00);
    chk(cpu_irq0 == 1, "R3 req one edge after mask write", cpu_irq0, 1);
    step();
    chk(cpu_irq0 == 0, "R3 req follows new mask", cpu_irq0, 0);

    // R4: cascade sweeps
    l0_src = 0; l1_src = 0;
    wr(5'h01, 8'h80); wr(5'h03, 8'h08);
    for (int side = 0; side < 2; side++) begin
      for (int mi = 0; mi < 11; mi++) begin
        wr(5'h08, side == 0 ? mval(mi) : 8'h00);
        wr(5'h0C, side == 1 ? mval(mi) : 8'h00);
        for (int s = 0; s < 256; s++) begin
          mp_src = 8'(s);
          step(); step();
          exp = 8'(s) & mval(mi);
          chk(cpu_irq0 == (side == 0 && exp != 0), "R4 cascade into level0 bit7", cpu_irq0, side == 0 && exp != 0);
          chk(cpu_irq1 == (side == 1 && exp != 0), "R4 cascade into level1 bit3", cpu_irq1, side == 1 && exp != 0);
        end
      end
    end
    wr(5'h08, 8'h01); wr(5'h0C, 8'h01); mp_src = 8'h01; step();
    rd(5'h00, d); chk(d == 8'h80, "R4 level0 bit7 from cascade", d, 8'h80);
    rd(5'h02, d); chk(d == 8'h08, "R4 level1 bit3 from cascade", d, 8'h08);
    chk(cpu_irq0 && cpu_irq1, "R4 one source to both levels", {cpu_irq1, cpu_irq0}, 3);

    // R5 + R10: full address sweep
    mp_src = 8'h96; l0_src = 8'h3C; l1_src = 8'h81;
    wr(5'h01, 8'hA5); wr(5'h03, 8'h5A); wr(5'h08, 8'h00); wr(5'h0C, 8'h42);
    step();
    for (int a = 0; a < 32; a++) begin
      case (a)
        0: exp = 8'h3C; 1: exp = 8'hA5; 2: exp = 8'h81; 3: exp = 8'h5A;
        4: exp = 8'h96; 8: exp = 8'h00; 12: exp = 8'h42;
        default: exp = 8'h00;
      endcase
      if (a == 2) exp = 8'h81 | 8'h08; // 0x96 & 0x42 != 0 cascades into bit 3
      rd(5'(a), d);
      chk(d == exp, (a == 1 || a == 3 || a == 8 || a == 12) ? "R5 mask readback" : "R10 address sweep", d, exp);
    end

    // R6: FIFO-full level bit and ignored status writes
    l0_src = 8'h01; step();
    wr(5'h00, 8'h00); wr(5'h02, 8'hFF); wr(5'h04, 8'h00);
    rd(5'h00, d); chk(d == 8'h01, "R6 fifo-full survives write", d, 1);
    rd(5'h02, d); chk(d == 8'h89, "R6 l1 status write ignored", d, 8'h89);
    rd(5'h04, d); chk(d == 8'h96, "R6 shared status write ignored", d, 8'h96);
    l0_src = 8'h00; step();
    rd(5'h00, d); chk(d == 8'h00, "R6 fifo-full follows input", d, 0);

    // R7: rising edge latch, sticky
    tick_in = 2'b01; step();
    chk(tick_irq == 2'b01, "R7 tick0 latched", tick_irq, 1);
    tick_in = 2'b00; step(); step();
    chk(tick_irq == 2'b01, "R7 tick0 sticky", tick_irq, 1);
    tick_in = 2'b10; step(); tick_in = 2'b00; step();
    chk(tick_irq == 2'b11, "R7 tick1 latched", tick_irq, 3);

    // R8: selective and full clear
    wr(5'h10, 8'h01);
    chk(tick_irq == 2'b10, "R8 clear bit0 only", tick_irq, 2);
    wr(5'h10, 8'h03);
    chk(tick_irq == 2'b00, "R8 clear both", tick_irq, 0);
    tick_in = 2'b11; step(); tick_in = 2'b00; step();
    wr(5'h10, 8'h02);
    chk(tick_irq == 2'b01, "R8 clear bit1 only", tick_irq, 1);
    wr(5'h10, 8'h01);

    // R9: set and clear in the same cycle
    tick_in = 2'b10; step(); tick_in = 2'b00; step();
    chk(tick_irq == 2'b10, "R9 setup flag1", tick_irq, 2);
    tick_in = 2'b01;
    wr(5'h10, 8'h03);
    chk(tick_irq == 2'b01, "R9 set wins, other cleared", tick_irq, 1);
    tick_in = 2'b00;

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule